// File: doc/BRIEF.md
# Lockable Configuration Register File

This block holds the setup state of a display controller: one configuration byte, a grid-count register, a shift-limit register, and a small output-map table. The table is reached through a pointer register and a single indirect data address. Software reaches every register with address and data byte pairs. One strobe carries writes and a separate request carries reads. Reads return their byte on a registered port one cycle later.

The configuration byte drives the neighbouring logic through outputs for run enable, display mode, font size and blink rate. Two of its bits never stay set. Writing them fires a one-cycle blink-synchronisation pulse or a one-cycle digit-data clear pulse.

A lock bit guards the setup registers against stray writes. While it is set, writes to the grid count, the shift limit and the output-map data port are dropped. The map pointer stays writable, so software can still walk the locked table and read it back. The lock bit itself also stays writable, so software can unlock.

Top module: `lockable_cfg_regs`

## Requirements
- R1: After reset, every register, the map pointer, every map entry, rd_data and both pulse outputs are 0.
- R2: A write to address 0x04 stores configuration bits 0 (run_en), 1 (locked), 2 (blink_fast), 3 (font16) and 6 (mode_ann), which appear on their outputs after the write edge. A read of 0x04 returns those bits in the same positions, bit 7 equal to blink_phase at the read edge, and bits 4 and 5 as 0.
- R3: While locked is 1, writes to 0x03 (grid_count), 0x0E (shift_limit) and 0x06 (map data) change nothing. Reads of these addresses still return the stored contents.
- R4: A write to 0x04 with bit 5 set drives digit_clear_pulse high for exactly the cycle after the write edge.
- R5: A write to 0x04 with bit 4 set drives blink_sync_pulse high for exactly the cycle after the write edge.
- R6: A write to address 0x00, or to any address that is not mapped, changes no state. A read of such an address returns 0.
- R7: Address 0x05 holds the map pointer. It is writable whether or not locked is set, and it reads back zero-extended. The stored value is the write data modulo MAP_DEPTH, where MAP_DEPTH is a power of two.
- R8: A read of 0x06 returns the map entry at the pointer. An accepted write to 0x06 stores into that entry. Each read and each accepted write of 0x06 advances the pointer by one, and the pointer wraps modulo MAP_DEPTH. A write dropped by the lock does not advance the pointer.
- R9: rd_data updates only at an edge where rd_en is 1 and holds its value otherwise. A read sees the state from before any write at the same edge.
- R10: When a pointer write and a data-port access happen at the same edge, the written pointer value wins over the advance.
- R11: While locked is 1, a write to 0x04 with bit 1 clear releases the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read address |
| blink_phase | input | 1 | Current blink phase, returned in configuration bit 7 |
| rd_data | output | 8 | Registered read data |
| run_en | output | 1 | Configuration bit 0 |
| locked | output | 1 | Configuration lock bit |
| blink_fast | output | 1 | Blink rate select |
| font16 | output | 1 | Selects the 16-segment font over the 14-segment font |
| mode_ann | output | 1 | Selects the annunciator display mode over the high-digit-count mode |
| blink_sync_pulse | output | 1 | One-cycle blink timing restart |
| digit_clear_pulse | output | 1 | One-cycle clear of digit and annunciator data |
| grid_count | output | 8 | Grid-count register |
| shift_limit | output | 8 | Shift-limit register |
| map_flat | output | MAP_DEPTH*8 | Output-map entries, entry i at bits 8i+7 down to 8i |

## Verification
The bench builds the block with MAP_DEPTH set to 8. With that depth, a three-bit pointer wraps after only a few data-port accesses. Random traffic therefore runs through pointer wrap, double advances from a read and a write at the same edge, and pointer writes with high bits that get dropped, many times over. Configuration writes set and clear the lock bit about half the time. The locked and unlocked paths to the grid, shift-limit and map registers are therefore mixed throughout the run.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

  localparam logic [7:0] ADDR_NOP       = 8'h00;
  localparam logic [7:0] ADDR_GRIDS     = 8'h03;
  localparam logic [7:0] ADDR_CFG       = 8'h04;
  localparam logic [7:0] ADDR_MAP_PTR   = 8'h05;
  localparam logic [7:0] ADDR_MAP_DATA  = 8'h06;
  localparam logic [7:0] ADDR_SHIFT_LIM = 8'h0E;

  localparam int BIT_RUN   = 0;
  localparam int BIT_LOCK  = 1;
  localparam int BIT_BLINK = 2;
  localparam int BIT_FONT  = 3;
  localparam int BIT_SYNC  = 4;
  localparam int BIT_CLR   = 5;
  localparam int BIT_MODE  = 6;
  localparam int BIT_PHASE = 7;

  typedef struct packed {
    logic mode_ann;
    logic font16;
    logic blink_fast;
    logic locked;
    logic run_en;
  } cfg_t;

  typedef struct packed {
    logic grids;
    logic cfg;
    logic ptr;
    logic data;
    logic shlim;
  } hit_t;

  function automatic cfg_t byte_to_cfg(input logic [7:0] b);
    cfg_t c;
    c.run_en     = b[BIT_RUN];
    c.locked     = b[BIT_LOCK];
    c.blink_fast = b[BIT_BLINK];
    c.font16     = b[BIT_FONT];
    c.mode_ann   = b[BIT_MODE];
    return c;
  endfunction

  function automatic logic [7:0] cfg_to_byte(input cfg_t c, input logic phase);
    logic [7:0] b;
    b            = 8'h00;
    b[BIT_RUN]   = c.run_en;
    b[BIT_LOCK]  = c.locked;
    b[BIT_BLINK] = c.blink_fast;
    b[BIT_FONT]  = c.font16;
    b[BIT_MODE]  = c.mode_ann;
    b[BIT_PHASE] = phase;
    return b;
  endfunction

endpackage

// File: rtl/lcr_decode.sv
module lcr_decode
  import lcr_pkg::*;
(
  input  logic       en,
  input  logic [7:0] addr,
  output hit_t       hit
);

  always_comb begin
    hit       = '0;
    hit.grids = en && (addr == ADDR_GRIDS);
    hit.cfg   = en && (addr == ADDR_CFG);
    hit.ptr   = en && (addr == ADDR_MAP_PTR);
    hit.data  = en && (addr == ADDR_MAP_DATA);
    hit.shlim = en && (addr == ADDR_SHIFT_LIM);
  end

endmodule

// File: rtl/lcr_map.sv
module lcr_map #(
  parameter int MAP_DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ptr_wr_en,
  input  logic [7:0]             ptr_wr_val,
  input  logic                   data_wr_en,
  input  logic [7:0]             data_wr_val,
  input  logic                   data_rd_en,
  output logic [7:0]             ptr_byte,
  output logic [7:0]             entry_val,
  output logic [MAP_DEPTH*8-1:0] map_flat
);

  localparam int PTR_W = (MAP_DEPTH > 1) ? $clog2(MAP_DEPTH) : 1;

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [7:0]       ent_q [MAP_DEPTH];

  // pointer next state: an explicit write beats the access advance
  always_comb begin
    if (ptr_wr_en) begin
      ptr_d = ptr_wr_val[PTR_W-1:0];
    end else begin
      ptr_d = ptr_q + PTR_W'(data_wr_en) + PTR_W'(data_rd_en);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_wr_en || data_wr_en || data_rd_en) begin
      ptr_q <= ptr_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < MAP_DEPTH; g++) begin : g_ent
      logic ent_en;
      assign ent_en = data_wr_en && (ptr_q == PTR_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent_q[g] <= '0;
        end else if (ent_en) begin
          ent_q[g] <= data_wr_val;
        end
      end
      assign map_flat[g*8 +: 8] = ent_q[g];
    end
  endgenerate

  assign entry_val = ent_q[ptr_q];
  assign ptr_byte  = 8'(ptr_q);

endmodule

// File: rtl/lockable_cfg_regs.sv
module lockable_cfg_regs
  import lcr_pkg::*;
#(
  parameter int MAP_DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [7:0]             wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   rd_en,
  input  logic [7:0]             rd_addr,
  input  logic                   blink_phase,
  output logic [7:0]             rd_data,
  output logic                   run_en,
  output logic                   locked,
  output logic                   blink_fast,
  output logic                   font16,
  output logic                   mode_ann,
  output logic                   blink_sync_pulse,
  output logic                   digit_clear_pulse,
  output logic [7:0]             grid_count,
  output logic [7:0]             shift_limit,
  output logic [MAP_DEPTH*8-1:0] map_flat
);

  hit_t wh, rh;

  lcr_decode u_wdec (.en(wr_en), .addr(wr_addr), .hit(wh));
  lcr_decode u_rdec (.en(rd_en), .addr(rd_addr), .hit(rh));

  cfg_t       cfg_q, cfg_d;
  logic [7:0] grid_q, grid_d;
  logic [7:0] shl_q, shl_d;
  logic [7:0] rd_q, rd_d;
  logic       clr_q, clr_d;
  logic       sync_q, sync_d;
  logic       grid_en, shl_en, data_wr_ok;
  logic [7:0] ptr_byte, entry_val;

  // lock gates the protected set only
  assign grid_en    = wh.grids && !cfg_q.locked;
  assign shl_en     = wh.shlim && !cfg_q.locked;
  assign data_wr_ok = wh.data  && !cfg_q.locked;

  lcr_map #(.MAP_DEPTH(MAP_DEPTH)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_wr_en  (wh.ptr),
    .ptr_wr_val (wr_data),
    .data_wr_en (data_wr_ok),
    .data_wr_val(wr_data),
    .data_rd_en (rh.data),
    .ptr_byte   (ptr_byte),
    .entry_val  (entry_val),
    .map_flat   (map_flat)
  );

  // write next state
  always_comb begin
    cfg_d  = byte_to_cfg(wr_data);
    grid_d = wr_data;
    shl_d  = wr_data;
    clr_d  = wh.cfg && wr_data[BIT_CLR];
    sync_d = wh.cfg && wr_data[BIT_SYNC];
  end

  // read next state, sees pre-write contents
  always_comb begin
    rd_d = 8'h00;
    unique case (1'b1)
      rh.cfg:   rd_d = cfg_to_byte(cfg_q, blink_phase);
      rh.grids: rd_d = grid_q;
      rh.shlim: rd_d = shl_q;
      rh.ptr:   rd_d = ptr_byte;
      rh.data:  rd_d = entry_val;
      default:  rd_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wh.cfg) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grid_q <= '0;
    end else if (grid_en) begin
      grid_q <= grid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shl_q <= '0;
    end else if (shl_en) begin
      shl_q <= shl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      clr_q  <= clr_d;
      sync_q <= sync_d;
    end
  end

  assign rd_data           = rd_q;
  assign run_en            = cfg_q.run_en;
  assign locked            = cfg_q.locked;
  assign blink_fast        = cfg_q.blink_fast;
  assign font16            = cfg_q.font16;
  assign mode_ann          = cfg_q.mode_ann;
  assign blink_sync_pulse  = sync_q;
  assign digit_clear_pulse = clr_q;
  assign grid_count        = grid_q;
  assign shift_limit       = shl_q;

endmodule

// File: rtl/lcr_checker.sv
module lcr_checker
  import lcr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       run_en,
  input logic       locked,
  input logic       blink_fast,
  input logic       font16,
  input logic       mode_ann,
  input logic       blink_sync_pulse,
  input logic       digit_clear_pulse,
  input logic [7:0] grid_count,
  input logic [7:0] shift_limit
);

  AST_CLEAR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    digit_clear_pulse |-> $past(wr_en && wr_addr == ADDR_CFG && wr_data[BIT_CLR])); // R4

  AST_SYNC_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    blink_sync_pulse |-> $past(wr_en && wr_addr == ADDR_CFG && wr_data[BIT_SYNC])); // R5

  AST_GRID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && wr_addr == ADDR_GRIDS) |=> $stable(grid_count)); // R3

  AST_SHLIM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && wr_addr == ADDR_SHIFT_LIM) |=> $stable(shift_limit)); // R3

  AST_NOP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_NOP) |=>
      $stable({run_en, locked, blink_fast, font16, mode_ann, grid_count, shift_limit})); // R6

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R9

endmodule

bind lockable_cfg_regs lcr_checker u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .wr_en            (wr_en),
  .wr_addr          (wr_addr),
  .wr_data          (wr_data),
  .rd_en            (rd_en),
  .rd_data          (rd_data),
  .run_en           (run_en),
  .locked           (locked),
  .blink_fast       (blink_fast),
  .font16           (font16),
  .mode_ann         (mode_ann),
  .blink_sync_pulse (blink_sync_pulse),
  .digit_clear_pulse(digit_clear_pulse),
  .grid_count       (grid_count),
  .shift_limit      (shift_limit)
);

// File: tb/lockable_cfg_regs_tb.sv
module lockable_cfg_regs_tb;

  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en, rd_en, blink_phase;
  logic [7:0]       wr_addr, wr_data, rd_addr;
  logic [7:0]       rd_data, grid_count, shift_limit;
  logic             run_en, locked, blink_fast, font16, mode_ann;
  logic             blink_sync_pulse, digit_clear_pulse;
  logic [DEPTH*8-1:0] map_flat;

  int n_chk  = 0;
  int n_fail = 0;

  // model state
  logic [7:0] m_cfg, m_grid, m_shl, m_rd;
  logic [2:0] m_ptr;
  logic [7:0] m_map [DEPTH];

  always #5 clk = ~clk;

  lockable_cfg_regs #(.MAP_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .blink_phase(blink_phase), .rd_data(rd_data),
    .run_en(run_en), .locked(locked), .blink_fast(blink_fast), .font16(font16),
    .mode_ann(mode_ann), .blink_sync_pulse(blink_sync_pulse),
    .digit_clear_pulse(digit_clear_pulse), .grid_count(grid_count),
    .shift_limit(shift_limit), .map_flat(map_flat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a, input logic bp);
    case (a)
      8'h04:   return {bp, m_cfg[6:0]};
      8'h03:   return m_grid;
      8'h0E:   return m_shl;
      8'h05:   return {5'b0, m_ptr};
      8'h06:   return m_map[m_ptr];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    case (a)
      8'h04:   return "R2";
      8'h03:   return "R3";
      8'h0E:   return "R3";
      8'h05:   return "R7";
      8'h06:   return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic cyc(input logic we, input logic [7:0] wa, input logic [7:0] wd,
                     input logic re, input logic [7:0] ra, input logic bp);
    logic [7:0] exp_rd;
    logic       exp_clr, exp_sync, lk;
    logic [2:0] adv;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra; blink_phase = bp;
    exp_rd   = re ? exp_read(ra, bp) : m_rd;
    exp_clr  = we && wa == 8'h04 && wd[5];
    exp_sync = we && wa == 8'h04 && wd[4];
    lk       = m_cfg[1];
    adv      = 3'((re && ra == 8'h06) ? 1 : 0) + 3'((we && wa == 8'h06 && !lk) ? 1 : 0);
    if (we && wa == 8'h06 && !lk) m_map[m_ptr] = wd;
    if (we && wa == 8'h05) m_ptr = wd[2:0];
    else m_ptr = m_ptr + adv;
    if (we && wa == 8'h04) m_cfg = wd & 8'h4F;
    if (we && wa == 8'h03 && !lk) m_grid = wd;
    if (we && wa == 8'h0E && !lk) m_shl = wd;
    @(posedge clk);
    #1;
    if (re) check(read_tag(ra), rd_data, exp_rd);
    else    check("R9", rd_data, exp_rd);
    m_rd = exp_rd;
    check("R4", digit_clear_pulse, exp_clr);
    check("R5", blink_sync_pulse, exp_sync);
    check("R2", {mode_ann, font16, blink_fast, locked, run_en},
          {m_cfg[6], m_cfg[3], m_cfg[2], m_cfg[1], m_cfg[0]});
    check("R3", {grid_count, shift_limit}, {m_grid, m_shl});
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  function automatic logic [7:0] pick_addr();
    case ($urandom % 8)
      0:       return 8'h00;
      1:       return 8'h03;
      2:       return 8'h04;
      3:       return 8'h05;
      4:       return 8'h06;
      5:       return 8'h0E;
      6:       return 8'($urandom);
      default: return 8'h06;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; blink_phase = 1'b0;
    m_cfg = '0; m_grid = '0; m_shl = '0; m_rd = '0; m_ptr = '0;
    for (int i = 0; i < DEPTH; i++) m_map[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", {rd_data, grid_count, shift_limit}, 24'h0);
    check("R1", {run_en, locked, blink_fast, font16, mode_ann,
                 blink_sync_pulse, digit_clear_pulse}, 7'h0);
    check("R1", map_flat, '0);

    // R2/R4/R5: all bits set, pulses fire, phase read back
    cyc(1, 8'h04, 8'hFF, 0, 8'h00, 0);
    cyc(0, 8'h00, 8'h00, 1, 8'h04, 1);
    check("R2", rd_data, 8'hCF);
    // R3: locked writes dropped, reads work
    cyc(1, 8'h03, 8'h55, 0, 8'h00, 0);
    cyc(1, 8'h0E, 8'h66, 1, 8'h03, 0);
    check("R3", grid_count, 8'h00);
    cyc(1, 8'h06, 8'h77, 1, 8'h0E, 0);
    check("R3", map_flat[7:0], 8'h00);
    // R7: pointer writable while locked
    cyc(1, 8'h05, 8'hFD, 1, 8'h05, 0);
    cyc(0, 8'h00, 8'h00, 1, 8'h05, 0);
    check("R7", rd_data, 8'h05);
    // R11: unlock
    cyc(1, 8'h04, 8'h00, 0, 8'h00, 0);
    check("R11", locked, 1'b0);
    // R8: wrap of pointer
    cyc(1, 8'h05, 8'h07, 0, 8'h00, 0);
    cyc(1, 8'h06, 8'hAA, 0, 8'h00, 0);
    cyc(1, 8'h06, 8'hBB, 1, 8'h05, 0);
    cyc(0, 8'h00, 8'h00, 1, 8'h05, 0);
    check("R8", rd_data, 8'h01);
    check("R8", {map_flat[63:56], map_flat[7:0]}, 16'hAABB);
    // R10: pointer write wins over a same-edge data read
    cyc(1, 8'h05, 8'h03, 1, 8'h06, 0);
    cyc(0, 8'h00, 8'h00, 1, 8'h05, 0);
    check("R10", rd_data, 8'h03);
    // R6: no-op and unmapped writes
    cyc(1, 8'h00, 8'hFF, 1, 8'h00, 1);
    cyc(1, 8'h7B, 8'hFF, 1, 8'h9C, 1);
    check("R6", {run_en, locked, blink_fast, font16, mode_ann}, 5'h0);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 3) != 0, pick_addr(), 8'($urandom),
          ($urandom % 2) == 1, pick_addr(), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule